// File: doc/BRIEF.md
# Shared Counter Timebase with Event Flags

This block is the common time reference for a group of four capture/compare modules. It holds a 16-bit up-counter, exposed as separate high and low bytes, that every module compares against or captures from. The counter advances from one of four selectable sources: the system clock divided by twelve, the system clock divided by two, overflow pulses from a neighbouring timer, or rising edges on an external pin after synchronisation.

Counting is controlled by a run bit. An optional idle-stop setting freezes the counter while the device is idle. When the counter wraps from all ones to zero, an overflow flag is set. Each module reports its match or capture events through a pulse, and each pulse sets a sticky per-module flag. Hardware only ever sets these flags and software only ever clears them. This is done through a byte-wide control/status write. The overflow flag, gated by its enable, and the module flags are combined into one interrupt request.

Top module: `shared_timebase`

## Requirements
- R1: After reset the count is 0, every flag is 0, the run bit is 0, `irq` is 0 and `statusByte` reads 0x00.
- R2: A `ctlWrEn` write loads the run bit from `ctlWrData[6]`, which reads back on `statusByte[6]`. The count changes only in cycles where the run bit is 1.
- R3: With `srcSel` = 0 the count advances by exactly one every 12 running clock cycles. The divider keeps its phase while the run bit is 0.
- R4: With `srcSel` = 1 the count advances by exactly one every 2 running clock cycles.
- R5: With `srcSel` = 2 the count advances by one for each running cycle in which `tmrOvf` is 1.
- R6: With `srcSel` = 3 the count advances by one per rising edge of `extPin`. The edge is seen two clocks after a two-stage synchroniser. A pin held high counts once, and `tmrOvf` has no effect in this mode.
- R7: When the count is 0xFFFF and advances, it becomes 0x0000 and the overflow flag (`statusByte[7]`) is set.
- R8: While both `idleStop` and `idleMode` are 1 the count is frozen. Either input alone does not stop it.
- R9: A 1 on `modEvent[i]` sets module flag i (`statusByte[i]`, i = 0..3). Hardware never clears a flag.
- R10: A write clears each flag whose data bit is 0 (bit 7 for overflow, bits 3..0 for the modules). A data bit of 1 leaves its flag unchanged, so software cannot set a flag.
- R11: If a module event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R12: `irq` is 1 exactly when (overflow flag AND `ovfIntEn`) or any module flag is 1.
- R13: `countHi`/`countLo` are the upper and lower count bytes. `statusByte[5:4]` always read 0, and write bits 5:4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcSel | input | 2 | Count source: 0 clk/12, 1 clk/2, 2 timer overflow, 3 external pin |
| idleStop | input | 1 | Freeze the counter during idle |
| idleMode | input | 1 | Device is idle |
| ovfIntEn | input | 1 | Let the overflow flag raise the interrupt |
| tmrOvf | input | 1 | Overflow pulse from a neighbouring timer |
| extPin | input | 1 | Asynchronous external count pin |
| modEvent | input | 4 | Match/capture pulses from modules 0..3 |
| ctlWrEn | input | 1 | Control/status byte write strobe |
| ctlWrData | input | 8 | Write data: bit 7 keep overflow, bit 6 run, bits 3..0 keep module flags |
| countHi | output | 8 | Counter upper byte |
| countLo | output | 8 | Counter lower byte |
| ovfFlag | output | 1 | Overflow flag |
| modFlag | output | 4 | Module flags |
| irq | output | 1 | Combined interrupt request |
| statusByte | output | 8 | {overflow, run, 0, 0, module flags 3..0} |

## Verification
A prescaler left at the wrong phase shows up as a count that is one step early or late. It appears on `countLo` within one division period after the run bit is set, so the bench checks the count on both sides of every expected step. A flag register that drops a set, or lets a clear win over a set, shows on `statusByte` and `irq` on the cycle after the write. The bench sweeps every event pattern against every clear mask. An off-by-one in the wrap detection shows only at the 0xFFFF-to-0 step, which the bench reaches by counting timer-overflow pulses through the full range.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int MOD_N   = 4;
  localparam int STAT_W  = 8;
  localparam int BIT_OVF = 7;
  localparam int BIT_RUN = 6;

  typedef enum logic [1:0] {
    SRC_DIV_SLOW = 2'd0,
    SRC_DIV_FAST = 2'd1,
    SRC_TMR_OVF  = 2'd2,
    SRC_EXT_PIN  = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic             inc;
    logic             runLoad;
    logic             runVal;
    logic             ovfClr;
    logic [MOD_N-1:0] modSet;
    logic [MOD_N-1:0] modClr;
  } stbStrobe_t;
endpackage

// File: rtl/stb_ctrl.sv
module stb_ctrl
  import stb_pkg::*;
#(
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       srcSel,
  input  logic             runQ,
  input  logic             idleStop,
  input  logic             idleMode,
  input  logic             tmrOvf,
  input  logic             extPin,
  input  logic [MOD_N-1:0] modEvent,
  input  logic             wrEn,
  input  logic             wrOvfKeep,
  input  logic             wrRun,
  input  logic [MOD_N-1:0] wrModKeep,
  output stbStrobe_t       strb
);
  localparam int PRE_W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(DIV_SLOW - 1);
  localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(DIV_FAST - 1);

  srcSel_e srcMode;
  assign srcMode = srcSel_e'(srcSel);

  logic gateOn;
  assign gateOn = runQ && !(idleStop && idleMode);

  // prescaler shared by both divided-clock sources
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] preLimit;
  logic             divMode;
  logic             preHit;

  assign divMode  = (srcMode == SRC_DIV_SLOW) || (srcMode == SRC_DIV_FAST);
  assign preLimit = (srcMode == SRC_DIV_SLOW) ? LIM_SLOW : LIM_FAST;
  assign preHit   = (pre >= preLimit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pre <= '0;
    end else if (gateOn && divMode) begin
      pre <= preHit ? '0 : pre + PRE_W'(1);
    end
  end

  // external pin synchroniser plus one edge-detect stage
  logic [SYNC_STAGES:0] syncQ;
  logic                 extRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-1:0], extPin};
    end
  end

  assign extRise = syncQ[SYNC_STAGES-1] && !syncQ[SYNC_STAGES];

  logic srcTick;
  always_comb begin
    unique case (srcMode)
      SRC_DIV_SLOW,
      SRC_DIV_FAST: srcTick = preHit;
      SRC_TMR_OVF:  srcTick = tmrOvf;
      SRC_EXT_PIN:  srcTick = extRise;
      default:      srcTick = 1'b0;
    endcase
  end

  assign strb.inc     = gateOn && srcTick;
  assign strb.runLoad = wrEn;
  assign strb.runVal  = wrRun;
  assign strb.ovfClr  = wrEn && !wrOvfKeep;

  for (genvar gi = 0; gi < MOD_N; gi++) begin : g_modStrb
    assign strb.modSet[gi] = modEvent[gi];
    assign strb.modClr[gi] = wrEn && !wrModKeep[gi];
  end

  AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !strb.inc); // R2
  AST_IDLE_HALT: assert property (@(posedge clk) disable iff (!rstN)
    (idleStop && idleMode) |-> !strb.inc); // R8
  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pre < PRE_W'(DIV_SLOW)); // R3
  AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (srcMode == SRC_EXT_PIN && strb.inc) |=> (!strb.inc || srcMode != SRC_EXT_PIN)); // R6
endmodule

// File: rtl/stb_dp.sv
module stb_dp
  import stb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  stbStrobe_t       strb,
  output logic [CNT_W-1:0] count,
  output logic             runQ,
  output logic             ovfFlag,
  output logic [MOD_N-1:0] modFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic wrapNow;
  assign wrapNow = strb.inc && (count == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.inc) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ <= 1'b0;
    end else if (strb.runLoad) begin
      runQ <= strb.runVal;
    end
  end

  // hardware set has priority over software clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (wrapNow) begin
      ovfFlag <= 1'b1;
    end else if (strb.ovfClr) begin
      ovfFlag <= 1'b0;
    end
  end

  for (genvar gi = 0; gi < MOD_N; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN) begin
        modFlag[gi] <= 1'b0;
      end else if (strb.modSet[gi]) begin
        modFlag[gi] <= 1'b1;
      end else if (strb.modClr[gi]) begin
        modFlag[gi] <= 1'b0;
      end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      strb.modSet[gi] |=> modFlag[gi]); // R11
    AST_HW_NO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (modFlag[gi] && !strb.modClr[gi]) |=> modFlag[gi]); // R9
    AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      (strb.modClr[gi] && !strb.modSet[gi]) |=> !modFlag[gi]); // R10
  end

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inc && count == CNT_MAX) |=> (count == '0 && ovfFlag)); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.inc |=> $stable(count)); // R2
endmodule

// File: rtl/shared_timebase.sv
module shared_timebase
  import stb_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           srcSel,
  input  logic                 idleStop,
  input  logic                 idleMode,
  input  logic                 ovfIntEn,
  input  logic                 tmrOvf,
  input  logic                 extPin,
  input  logic [MOD_N-1:0]     modEvent,
  input  logic                 ctlWrEn,
  input  logic [STAT_W-1:0]    ctlWrData,
  output logic [CNT_W/2-1:0]   countHi,
  output logic [CNT_W/2-1:0]   countLo,
  output logic                 ovfFlag,
  output logic [MOD_N-1:0]     modFlag,
  output logic                 irq,
  output logic [STAT_W-1:0]    statusByte
);
  localparam int HALF_W = CNT_W / 2;

  stbStrobe_t       strb;
  logic [CNT_W-1:0] count;
  logic             runQ;
  logic             unusedWr;

  assign unusedWr = ^ctlWrData[BIT_RUN-1:MOD_N];

  stb_ctrl #(
    .DIV_SLOW   (DIV_SLOW),
    .DIV_FAST   (DIV_FAST),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .srcSel   (srcSel),
    .runQ     (runQ),
    .idleStop (idleStop),
    .idleMode (idleMode),
    .tmrOvf   (tmrOvf),
    .extPin   (extPin),
    .modEvent (modEvent),
    .wrEn     (ctlWrEn),
    .wrOvfKeep(ctlWrData[BIT_OVF]),
    .wrRun    (ctlWrData[BIT_RUN]),
    .wrModKeep(ctlWrData[MOD_N-1:0]),
    .strb     (strb)
  );

  stb_dp #(
    .CNT_W(CNT_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .count  (count),
    .runQ   (runQ),
    .ovfFlag(ovfFlag),
    .modFlag(modFlag)
  );

  assign countHi    = count[CNT_W-1:HALF_W];
  assign countLo    = count[HALF_W-1:0];
  assign irq        = (ovfFlag && ovfIntEn) || (|modFlag);
  assign statusByte = {ovfFlag, runQ, {(BIT_RUN - MOD_N){1'b0}}, modFlag};

  AST_IRQ_MOD: assert property (@(posedge clk) disable iff (!rstN)
    (|modFlag) |-> irq); // R12
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfFlag && modFlag == '0) |-> !irq); // R12
endmodule

// File: tb/sim_shared_timebase.sv
module sim_shared_timebase;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] srcSel;
  logic       idleStop, idleMode, ovfIntEn, tmrOvf, extPin;
  logic [3:0] modEvent;
  logic       ctlWrEn;
  logic [7:0] ctlWrData;
  logic [7:0] countHi, countLo, statusByte;
  logic       ovfFlag, irq;
  logic [3:0] modFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  shared_timebase u0 (
    .clk(clk), .rstN(rstN), .srcSel(srcSel), .idleStop(idleStop),
    .idleMode(idleMode), .ovfIntEn(ovfIntEn), .tmrOvf(tmrOvf), .extPin(extPin),
    .modEvent(modEvent), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .countHi(countHi), .countLo(countLo), .ovfFlag(ovfFlag), .modFlag(modFlag),
    .irq(irq), .statusByte(statusByte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    ctlWrData = d;
    ctlWrEn   = 1'b1;
    tick(1);
    ctlWrEn   = 1'b0;
    ctlWrData = 8'h00;
  endtask

  task automatic doReset();
    rstN = 1'b0; srcSel = 2'd0; idleStop = 0; idleMode = 0; ovfIntEn = 0;
    tmrOvf = 0; extPin = 0; modEvent = 4'h0; ctlWrEn = 0; ctlWrData = 8'h00;
    tick(2);
    rstN = 1'b1;
    tick(1);
  endtask

  function automatic logic [15:0] cnt();
    return {countHi, countLo};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int exp;
    logic [3:0] prev;

    // R1 reset state
    doReset();
    chk("R1 count", cnt(), 0);
    chk("R1 status", statusByte, 8'h00);
    chk("R1 irq", irq, 0);

    // R3 divide by 12, divider holds phase while stopped
    srcSel = 2'd0;
    wr(8'h40);
    chk("R2 run bit", statusByte[6], 1);
    for (int k = 1; k <= 4; k++) begin
      tick(11);
      chk("R3 before step", cnt(), k - 1);
      tick(1);
      chk("R3 step", cnt(), k);
    end
    wr(8'h00);
    tick(30);
    chk("R2 stopped count", cnt(), 4);
    chk("R2 run bit clear", statusByte[6], 0);
    wr(8'h40);
    tick(10);
    chk("R3 held phase", cnt(), 4);
    tick(1);
    chk("R3 resumed step", cnt(), 5);

    // R4 divide by 2
    doReset();
    srcSel = 2'd1;
    wr(8'h40);
    for (int k = 1; k <= 8; k++) begin
      tick(1);
      chk("R4 before step", cnt(), k - 1);
      tick(1);
      chk("R4 step", cnt(), k);
    end

    // R5 timer overflow pulses
    doReset();
    srcSel = 2'd2;
    wr(8'h40);
    exp = 0;
    for (int i = 0; i < 40; i++) begin
      tmrOvf = ((i * 7) % 3 == 0) || (i % 5 == 1);
      tick(1);
      if (tmrOvf) exp++;
      chk("R5 pulse count", cnt(), exp);
    end
    tmrOvf = 0;

    // R6 external pin edges
    doReset();
    srcSel = 2'd3;
    wr(8'h40);
    for (int e = 1; e <= 5; e++) begin
      extPin = 1'b1;
      tick(2);
      chk("R6 sync latency", cnt(), e - 1);
      tick(3);
      chk("R6 edge counted", cnt(), e);
      extPin = 1'b0;
      tick(4);
    end
    extPin = 1'b1;
    tmrOvf = 1'b1;
    tick(25);
    chk("R6 held high once", cnt(), 6);
    extPin = 1'b0;
    tmrOvf = 1'b0;

    // R8 idle stop
    doReset();
    srcSel = 2'd2;
    wr(8'h40);
    tmrOvf = 1'b1; idleMode = 1'b1; idleStop = 1'b0;
    tick(5);
    chk("R8 idle alone counts", cnt(), 5);
    idleStop = 1'b1;
    tick(5);
    chk("R8 idle stop freezes", cnt(), 5);
    idleMode = 1'b0;
    tick(3);
    chk("R8 stop bit alone counts", cnt(), 8);
    tmrOvf = 1'b0; idleStop = 1'b0;

    // R7 overflow and R13 byte split
    doReset();
    srcSel = 2'd2;
    tmrOvf = 1'b1;
    wr(8'h40);
    tick(256);
    chk("R13 hi byte", countHi, 8'h01);
    chk("R13 lo byte", countLo, 8'h00);
    tick(65279);
    chk("R7 at max", cnt(), 16'hFFFF);
    chk("R7 no flag yet", ovfFlag, 0);
    tick(1);
    tmrOvf = 1'b0;
    chk("R7 wrapped", cnt(), 16'h0000);
    chk("R7 ovf flag", statusByte[7], 1);
    chk("R12 irq masked", irq, 0);
    ovfIntEn = 1'b1;
    #1;
    chk("R12 irq enabled", irq, 1);
    wr(8'hFF);
    chk("R10 keep ovf", ovfFlag, 1);
    chk("R13 bits 5:4 zero", statusByte, 8'hC0);
    wr(8'h4F);
    chk("R10 clear ovf", ovfFlag, 0);
    chk("R12 irq after clear", irq, 0);
    ovfIntEn = 1'b0;

    // R9 R10 R11 full sweep of event pattern against clear mask
    doReset();
    prev = 4'h0;
    for (int ev = 0; ev < 16; ev++) begin
      for (int m = 0; m < 16; m++) begin
        modEvent  = 4'(ev);
        ctlWrData = {1'b1, 3'b000, 4'(m)};
        ctlWrEn   = 1'b1;
        tick(1);
        modEvent  = 4'h0;
        ctlWrEn   = 1'b0;
        prev = (prev & 4'(m)) | 4'(ev);
        chk("R11 set vs clear", modFlag, prev);
        chk("R12 irq from modules", irq, (prev != 0));
      end
    end
    tick(3);
    chk("R9 flags sticky", modFlag, prev);
    modEvent = 4'b0101;
    tick(1);
    modEvent = 4'h0;
    chk("R9 event sets", statusByte[3:0], prev | 4'b0101);
    wr(8'hB0);
    chk("R10 clear all modules", statusByte, 8'h00);
    wr(8'h8F);
    chk("R10 cannot set", statusByte, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule